// File: doc/BRIEF.md
# Paired UART Baud Tick Generator

This block turns one 8-bit auto-reload timer setting into two baud tick streams for a UART, one for the transmitter and one for the receiver. A count event is made by a prescaler that divides either the system clock or a synchronised external-oscillator pulse. Each count event advances two 8-bit up-counters that share a single reload byte. The transmit counter runs freely. The receive counter is a private copy that is forced back to the reload value whenever a start bit is reported. Each counter's overflows go through a divide-by-two stage, and that stage emits the tick.

The baud period is twice the counter period, because each counter is set to overflow at double the bit rate. Restarting the receive counter on a start edge lets a reception begin at any moment, whatever phase the transmit timer is in. The first receive tick then follows one full bit period after the start report.

Top module: `baud_pair_gen`

## Requirements
- R1: During and after a synchronous active-high reset, both tick outputs are low and both counters and both divide-by-two stages start from zero. From zero, the first transmit tick follows 256 + (256 − reload) count events.
- R2: The transmit counter advances by one on each count event. A count event at 0xFF reloads it from the reload byte. Every second such overflow gives a one-cycle txBaudTick, high in the cycle after the clock edge of the overflowing count event. The tick is never high on two cycles in a row.
- R3: The receive counter counts the same count events, reloads from the same reload byte, and has its own divide-by-two stage that drives rxBaudTick in the same way.
- R4: A startDet pulse while timerEn is high loads the receive counter from the reload byte and clears its divide-by-two stage. No receive tick is produced for that cycle, and the transmit path is not affected. The first receive tick then comes 2·(256 − reload) count events later.
- R5: In steady operation, consecutive ticks on either output are 2·(256 − reload)·N system cycles apart, where N is the prescale ratio.
- R6: clkSel encoding: 0 = every system cycle, 1 = every 4th, 2 = every 12th, 3 = every 48th, 4 = every 8th extOscTick pulse.
- R7: While timerEn is low, the counters, the divide-by-two stages and the prescaler hold their values, no tick is produced, and startDet is ignored.
- R8: In any cycle where clkSel differs from its value in the previous cycle, the prescaler count returns to zero and no count event occurs.
- R9: A change of the reload byte does not alter a count in progress. The new value is used at the next overflow or forced reload.
- R10: clkSel codes 5, 6 and 7 produce no count events, so no ticks appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| timerEn | input | 1 | Timer run enable |
| clkSel | input | 3 | Count source and prescale select |
| reloadVal | input | 8 | Shared auto-reload byte |
| extOscTick | input | 1 | Synchronised single-cycle external oscillator pulse |
| startDet | input | 1 | Single-cycle start-bit detected pulse |
| txBaudTick | output | 1 | Transmit baud tick |
| rxBaudTick | output | 1 | Receive baud tick |

## Verification
Tick spacing is measured under each of the five count sources. This separates the prescale ratios and confirms the period formula, with external pulses arriving every third cycle. Start pulses are placed at arbitrary phases of the free-running transmit timer. The timing of the first receive tick then shows whether the forced reload and the clearing of the divide-by-two stage both happened, and whether the transmit stream kept its rhythm. Further phases disable the timer, switch the select code, change the reload byte midway through a count, and select the unused codes. A cycle-by-cycle model compares both outputs on every clock throughout, so any drift in phase shows up at once.

// File: rtl/baud_pair_pkg.sv
package baud_pair_pkg;

  typedef enum logic [2:0] {
    SRC_SYS_1  = 3'd0,
    SRC_SYS_4  = 3'd1,
    SRC_SYS_12 = 3'd2,
    SRC_SYS_48 = 3'd3,
    SRC_EXT_8  = 3'd4
  } srcSel_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic countEn;   // one timer count event
    logic rxForce;   // restart receive timer from reload value
  } ctlStrobes_t;

endpackage

// File: rtl/baud_ctl.sv
module baud_ctl
  import baud_pair_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DIV_A   = 4,
  parameter int DIV_B   = 12,
  parameter int DIV_C   = 48,
  parameter int EXT_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             timerEn,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             extOscTick,
  input  logic             startDet,
  output ctlStrobes_t      strobes
);

  localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int MAX_CE = (DIV_C > EXT_DIV) ? DIV_C : EXT_DIV;
  localparam int MAX_D  = (MAX_AB > MAX_CE) ? MAX_AB : MAX_CE;
  localparam int PW     = (MAX_D > 2) ? $clog2(MAX_D) : 1;

  logic [PW-1:0]    preCnt;
  logic [SEL_W-1:0] prevSel;
  logic             selChanged;
  logic             srcPulse;
  logic [PW-1:0]    lastCnt;
  logic             atLast;

  assign selChanged = (clkSel != prevSel);

  // Source pulse and terminal prescale count per select code
  always_comb begin
    srcPulse = 1'b0;
    lastCnt  = '0;
    case (clkSel)
      SRC_SYS_1:  begin srcPulse = 1'b1;       lastCnt = '0;              end
      SRC_SYS_4:  begin srcPulse = 1'b1;       lastCnt = PW'(DIV_A - 1);  end
      SRC_SYS_12: begin srcPulse = 1'b1;       lastCnt = PW'(DIV_B - 1);  end
      SRC_SYS_48: begin srcPulse = 1'b1;       lastCnt = PW'(DIV_C - 1);  end
      SRC_EXT_8:  begin srcPulse = extOscTick; lastCnt = PW'(EXT_DIV - 1); end
      default:    begin srcPulse = 1'b0;       lastCnt = '0;              end
    endcase
  end

  assign atLast = (preCnt == lastCnt);

  always_ff @(posedge clk) begin
    prevSel <= clkSel;
    if (rst) begin
      preCnt <= '0;
    end else if (selChanged) begin
      preCnt <= '0;
    end else if (timerEn && srcPulse) begin
      preCnt <= atLast ? '0 : preCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.countEn = timerEn && !selChanged && srcPulse && atLast;
    strobes.rxForce = timerEn && startDet;
  end

endmodule

// File: rtl/baud_lane.sv
module baud_lane #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countEn,
  input  logic             forceLoad,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;
  logic             half;
  logic             wrap;

  assign wrap = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      half <= 1'b0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (forceLoad) begin
        cnt  <= reloadVal;
        half <= 1'b0;
      end else if (countEn) begin
        if (wrap) begin
          cnt  <= reloadVal;
          half <= ~half;
          tick <= half;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pair_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobes_t      strobes,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             txTick,
  output logic             rxTick
);

  localparam int LANES = 2;  // lane 0 transmit, lane 1 receive

  logic [LANES-1:0] laneTick;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic laneForce;
    if (g == 1) begin : gRx
      assign laneForce = strobes.rxForce;
    end else begin : gTx
      assign laneForce = 1'b0;
    end
    baud_lane #(.CNT_W(CNT_W)) lane_i (
      .clk      (clk),
      .rst      (rst),
      .countEn  (strobes.countEn),
      .forceLoad(laneForce),
      .reloadVal(reloadVal),
      .tick     (laneTick[g])
    );
  end

  assign txTick = laneTick[0];
  assign rxTick = laneTick[1];

endmodule

// File: rtl/baud_pair_gen.sv
module baud_pair_gen
  import baud_pair_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int SEL_W   = 3,
  parameter int DIV_A   = 4,
  parameter int DIV_B   = 12,
  parameter int DIV_C   = 48,
  parameter int EXT_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             timerEn,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             extOscTick,
  input  logic             startDet,
  output logic             txBaudTick,
  output logic             rxBaudTick
);

  ctlStrobes_t strobes;

  baud_ctl #(
    .SEL_W(SEL_W), .DIV_A(DIV_A), .DIV_B(DIV_B),
    .DIV_C(DIV_C), .EXT_DIV(EXT_DIV)
  ) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .timerEn   (timerEn),
    .clkSel    (clkSel),
    .extOscTick(extOscTick),
    .startDet  (startDet),
    .strobes   (strobes)
  );

  baud_dp #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .reloadVal(reloadVal),
    .txTick   (txBaudTick),
    .rxTick   (rxBaudTick)
  );

endmodule

// File: rtl/baud_pair_gen_chk.sv
module baud_pair_gen_chk #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             timerEn,
  input logic [SEL_W-1:0] clkSel,
  input logic [CNT_W-1:0] reloadVal,
  input logic             extOscTick,
  input logic             startDet,
  input logic             txBaudTick,
  input logic             rxBaudTick
);

  // R1: ticks are low in the cycle after any reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!txBaudTick && !rxBaudTick));

  // R2: a transmit tick is a single-cycle pulse
  a_r2_tx_single: assert property (@(posedge clk) disable iff (rst)
    txBaudTick |=> !txBaudTick);

  // R3: a receive tick is a single-cycle pulse
  a_r3_rx_single: assert property (@(posedge clk) disable iff (rst)
    rxBaudTick |=> !rxBaudTick);

  // R4: a forced receive reload gives no receive tick
  a_r4_force_no_rx: assert property (@(posedge clk) disable iff (rst)
    (timerEn && startDet) |=> !rxBaudTick);

  // R7: no ticks follow a disabled cycle
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !timerEn |=> (!txBaudTick && !rxBaudTick));

  // R8: a select change suppresses the count event
  a_r8_sel_change_quiet: assert property (@(posedge clk) disable iff (rst)
    !$stable(clkSel) |=> (!txBaudTick && !rxBaudTick));

  // R10: unused select codes never count
  a_r10_unused_sel: assert property (@(posedge clk) disable iff (rst)
    (clkSel > 3'd4) |=> (!txBaudTick && !rxBaudTick));

endmodule

bind baud_pair_gen baud_pair_gen_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) chk_i (.*);

// File: tb/baud_pair_gen_tb_top.sv
module baud_pair_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       timerEn;
  logic [2:0] clkSel;
  logic [7:0] reloadVal;
  logic       extOscTick;
  logic       startDet;
  logic       txBaudTick;
  logic       rxBaudTick;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    extOn = 1'b0;
  bit    finished = 1'b0;
  string curTag = "R1";

  // behavioural reference state
  int mTx, mRx, mPre, mPrev;
  bit mTxH, mRxH, expTx, expRx;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_pair_gen dut_i (
    .clk(clk), .rst(rst), .timerEn(timerEn), .clkSel(clkSel),
    .reloadVal(reloadVal), .extOscTick(extOscTick), .startDet(startDet),
    .txBaudTick(txBaudTick), .rxBaudTick(rxBaudTick)
  );

  function automatic int ratioOf(int s);
    case (s)
      0: return 1;
      1: return 4;
      2: return 12;
      3: return 48;
      4: return 8;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit ev, changed, src;
    int n;
    cyc++;
    ev = 1'b0;
    if (rst) begin
      mTx = 0; mRx = 0; mPre = 0; mTxH = 0; mRxH = 0;
      expTx = 0; expRx = 0; mPrev = int'(clkSel);
    end else begin
      changed = (int'(clkSel) != mPrev);
      mPrev = int'(clkSel);
      n = ratioOf(int'(clkSel));
      src = (clkSel == 3'd4) ? extOscTick : (n != 0);
      if (changed) mPre = 0;
      else if (timerEn && src) begin
        mPre = mPre + 1;
        if (mPre == n) begin mPre = 0; ev = 1'b1; end
      end
      expTx = 0; expRx = 0;
      if (ev) begin
        if (mTx == 255) begin mTx = reloadVal; expTx = mTxH; mTxH = !mTxH; end
        else mTx = mTx + 1;
      end
      if (timerEn && startDet) begin
        mRx = reloadVal; mRxH = 0;
      end else if (ev) begin
        if (mRx == 255) begin mRx = reloadVal; expRx = mRxH; mRxH = !mRxH; end
        else mRx = mRx + 1;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(curTag, "tx tick vs model", int'(txBaudTick), int'(expTx));
      check(curTag, "rx tick vs model", int'(rxBaudTick), int'(expRx));
    end
  end

  // external pulse source, every third cycle
  always @(negedge clk) extOscTick <= extOn && (cyc % 3 == 0);

  task automatic waitTick(bit rxSide, output int when);
    do @(negedge clk); while ((rxSide ? rxBaudTick : txBaudTick) !== 1'b1);
    when = cyc;
  endtask

  task automatic measure(string tag, bit rxSide, int exp);
    int t0, t1;
    waitTick(rxSide, t0);
    waitTick(rxSide, t1);
    check(tag, rxSide ? "rx spacing" : "tx spacing", t1 - t0, exp);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    int quiet, t0, t1;
    extOscTick = 1'b0;
    rst = 1'b1; timerEn = 1'b0; clkSel = 3'd0; reloadVal = 8'hFC; startDet = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "tx after reset", int'(txBaudTick), 0);
    check("R1", "rx after reset", int'(rxBaudTick), 0);
    rst = 1'b0; timerEn = 1'b1;
    curTag = "R1";
    t0 = cyc;
    waitTick(1'b0, t1);
    check("R1", "first tx tick from zero", t1 - t0, 256 + 4);

    // R2, R3, R5 at /1 with reload 0xFC
    curTag = "R2";
    measure("R2", 1'b0, 8);
    curTag = "R3";
    measure("R3", 1'b1, 8);

    // R4: start pulse restarts receive timing
    curTag = "R4";
    @(negedge clk); @(negedge clk); @(negedge clk);
    startDet = 1'b1;
    @(negedge clk);
    startDet = 1'b0;
    quiet = 0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (rxBaudTick) quiet++;
    end
    check("R4", "rx ticks before one bit", quiet, 0);
    @(negedge clk);
    check("R4", "rx tick one bit after start", int'(rxBaudTick), 1);

    // R6, R5: prescale ratios, reload 0xFE
    curTag = "R6";
    reloadVal = 8'hFE;
    clkSel = 3'd1;
    waitTick(1'b0, t0);
    measure("R6", 1'b0, 16);
    clkSel = 3'd2;
    waitTick(1'b0, t0);
    measure("R6", 1'b0, 48);
    clkSel = 3'd3;
    waitTick(1'b0, t0);
    measure("R5", 1'b0, 192);
    extOn = 1'b1;
    clkSel = 3'd4;
    waitTick(1'b0, t0);
    measure("R6", 1'b0, 96);
    extOn = 1'b0;

    // R7: disabled timer holds and ignores start
    curTag = "R7";
    clkSel = 3'd0;
    repeat (5) @(negedge clk);
    timerEn = 1'b0;
    quiet = 0;
    for (int i = 0; i < 40; i++) begin
      startDet = (i == 10);
      @(negedge clk);
      if (txBaudTick || rxBaudTick) quiet++;
    end
    startDet = 1'b0;
    check("R7", "ticks while disabled", quiet, 0);
    timerEn = 1'b1;
    repeat (30) @(negedge clk);

    // R8: select changes at several phases
    curTag = "R8";
    for (int k = 0; k < 6; k++) begin
      clkSel = (k % 2) ? 3'd1 : 3'd2;
      repeat (7 + k * 5) @(negedge clk);
    end
    clkSel = 3'd0;
    repeat (20) @(negedge clk);

    // R9: reload change during a count in progress
    curTag = "R9";
    reloadVal = 8'hF0;
    startDet = 1'b1;
    @(negedge clk);
    startDet = 1'b0;
    repeat (3) @(negedge clk);
    reloadVal = 8'hFC;
    quiet = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (rxBaudTick) quiet++;
    end
    check("R9", "rx quiet during old count", quiet, 0);
    @(negedge clk);
    check("R9", "rx tick after new reload", int'(rxBaudTick), 1);
    repeat (20) @(negedge clk);

    // R10: unused codes never count
    curTag = "R10";
    quiet = 0;
    for (int s = 5; s < 8; s++) begin
      clkSel = 3'(s);
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (txBaudTick || rxBaudTick) quiet++;
      end
    end
    check("R10", "ticks on unused codes", quiet, 0);
    clkSel = 3'd0;
    repeat (40) @(negedge clk);
    summary();
  end

endmodule